// File: doc/BRIEF.md
# DSP Address Generation Unit

This block computes one data-memory address per clock for a signal-processing datapath. It keeps its own small file of pointers, and each pointer carries its own buffer start and buffer length. Every pointer update is done by the unit's own adders, so the arithmetic datapath stays free for multiply-accumulate work. Each advance names a pointer, an addressing kind, a signed step and an access-size scale. The unit then emits an address and writes the updated pointer back.

There are four addressing kinds:

- plain linear stepping, which wraps modulo the address width;
- circular stepping over a buffer of any length, where overshoot past either end folds back into the buffer;
- circular stepping over an aligned power-of-two buffer, where the upper address bits stay fixed and only the low bits wrap;
- bit-reversed stepping for radix-2 FFT reordering, done as a reverse-carry add of half the transform size.

A separate flag chooses whether the address is emitted before or after the update. Decrementing uses a negative step.

Software-visible setup happens through two write ports. One loads a pointer. The other sets a pointer's buffer start and length. The emitted address is registered, so it appears in the cycle after the advance strobe, together with a valid flag.

Top module: `dsp_agu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, addr_valid is 0 and addr_out is 0. Reset clears every pointer, buffer start and buffer length to 0.
- R2: addr_valid is 1 in exactly the cycles that follow a cycle with adv high. In a cycle that follows one without adv, addr_out keeps its previous value.
- R3: With adv_mode = 3'b000 (linear, post), addr_out shows the pointer value before the update. The pointer then becomes pointer + scaled step, modulo 2^AW.
- R4: With adv_mode = 3'b001 (linear, pre), the updated pointer value is both stored and shown on addr_out.
- R5: The scaled step is adv_step (two's complement) multiplied by 1, 2, 4 or 8 for adv_scale = 0, 1, 2 or 3. A negative step decrements.
- R6: With adv_mode[2:1] = 2'b01 (circular), a pointer inside [start, start+length) moves by the scaled step. If the result is at or above start+length, length is subtracted. If it is below start, length is added. This holds for step magnitudes up to length-1. A configuration write takes effect from the next cycle.
- R7: With adv_mode[2:1] = 2'b10 (aligned circular), length must be a power of two and the buffer start is ignored. The bits at and above log2(length) are held. The low bits become (low + scaled step) mod length.
- R8: With adv_mode[2:1] = 2'b11 (bit-reversed), length is the power-of-two transform size. The low log2(length) bits step through bit-reversed order and the upper bits are held. Step and scale are ignored. For length 8 starting at 0, the post-mode sequence is 0, 4, 2, 6, 1, 5, 3, 7 and then repeats.
- R9: adv_mode[0] = 1 emits the updated pointer and adv_mode[0] = 0 emits the old pointer, for every kind.
- R10: A load to the pointer being advanced in the same cycle takes precedence over the update. The emitted address is still computed from the old pointer.
- R11: Advancing one pointer leaves every other pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write buffer start and length of one pointer |
| cfg_sel | input | PSEL_W | Pointer selected by the configuration write |
| cfg_base | input | AW | Buffer start address |
| cfg_len | input | AW | Buffer length, or power-of-two size |
| ld_we | input | 1 | Load a pointer value |
| ld_sel | input | PSEL_W | Pointer selected by the load |
| ld_val | input | AW | Value to load |
| adv | input | 1 | Advance strobe: emit an address and update the pointer |
| adv_sel | input | PSEL_W | Pointer to advance |
| adv_mode | input | 3 | [2:1] addressing kind, [0] pre-update emission |
| adv_step | input | SW | Signed step |
| adv_scale | input | 2 | Access-size shift of the step (0 to 3) |
| addr_valid | output | 1 | addr_out holds a fresh address |
| addr_out | output | AW | Registered emitted address |

## Verification
The bench sweeps start positions and signed steps across the whole circular buffer. This exposes an off-by-one in the end compare: a design with that fault would leave the pointer one past the end instead of folding it back to the start, and a missing lower-bound fold would let decrements escape below the buffer start. Aligned circular sweeps use an odd start address and a deliberately wrong buffer start. A design that borrowed into the upper bits, or used the start address, then shows a changed page. Bit-reversed runs check the literal 8-point order and a 16-point walk with nonzero upper bits, which catches a forward carry or a lost wrap. Load-versus-advance collisions and a separate untouched pointer catch a reversed write priority or a misrouted write-back.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        KIND_LIN  = 2'b00,
        KIND_CIRC = 2'b01,
        KIND_P2   = 2'b10,
        KIND_REV  = 2'b11
    } agu_kind_e;

endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
    parameter int AW     = 16,
    parameter int NPTR   = 4,
    parameter int PSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PSEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]     cfg_base,
    input  logic [AW-1:0]     cfg_len,
    input  logic              ld_we,
    input  logic [PSEL_W-1:0] ld_sel,
    input  logic [AW-1:0]     ld_val,
    input  logic              upd_we,
    input  logic [PSEL_W-1:0] upd_sel,
    input  logic [AW-1:0]     upd_val,
    input  logic [PSEL_W-1:0] rd_sel,
    output logic [AW-1:0]     rd_ptr,
    output logic [AW-1:0]     rd_base,
    output logic [AW-1:0]     rd_len
);

    logic [AW-1:0] ptr_arr  [NPTR];
    logic [AW-1:0] base_arr [NPTR];
    logic [AW-1:0] len_arr  [NPTR];

    for (genvar g = 0; g < NPTR; g++) begin : g_ent
        logic [AW-1:0] p_q;
        logic [AW-1:0] b_q;
        logic [AW-1:0] l_q;
        logic          hit_ld;
        logic          hit_upd;
        logic          hit_cfg;

        assign hit_ld  = ld_we  && (ld_sel  == PSEL_W'(g));
        assign hit_upd = upd_we && (upd_sel == PSEL_W'(g));
        assign hit_cfg = cfg_we && (cfg_sel == PSEL_W'(g));

        // load has priority over the advance write-back
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                p_q <= '0;
            end else if (hit_ld) begin
                p_q <= ld_val;
            end else if (hit_upd) begin
                p_q <= upd_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b_q <= '0;
                l_q <= '0;
            end else if (hit_cfg) begin
                b_q <= cfg_base;
                l_q <= cfg_len;
            end
        end

        assign ptr_arr[g]  = p_q;
        assign base_arr[g] = b_q;
        assign len_arr[g]  = l_q;
    end

    assign rd_ptr  = ptr_arr[rd_sel];
    assign rd_base = base_arr[rd_sel];
    assign rd_len  = len_arr[rd_sel];

endmodule

// File: rtl/agu_rev_carry.sv
module agu_rev_carry #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] span,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0] mask;
    logic [AW-1:0] half;
    logic [AW-1:0] low;
    logic [AW-1:0] low_m;
    logic [AW-1:0] half_m;
    logic [AW-1:0] sum_m;
    logic [AW-1:0] sum;

    assign mask = span - AW'(1);
    assign half = span >> 1;
    assign low  = cur & mask;

    // mirror operands so that a normal add carries toward the low bits
    for (genvar i = 0; i < AW; i++) begin : g_mirror
        assign low_m[i]  = low[AW-1-i];
        assign half_m[i] = half[AW-1-i];
        assign sum[i]    = sum_m[AW-1-i];
    end

    assign sum_m = low_m + half_m;
    assign nxt   = (cur & ~mask) | (sum & mask);

endmodule

// File: rtl/agu_step_calc.sv
module agu_step_calc
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8
) (
    input  agu_kind_e     kind,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [SW-1:0] step,
    input  logic [1:0]    scale,
    output logic [AW-1:0] nxt
);

    localparam int XW = AW + 2;

    logic signed [XW-1:0] step_x;
    logic signed [XW-1:0] step_s;
    logic signed [XW-1:0] raw;
    logic signed [XW-1:0] lo_bound;
    logic signed [XW-1:0] hi_bound;
    logic signed [XW-1:0] len_x;
    logic signed [XW-1:0] circ;
    logic [AW-1:0]        mask;
    logic [AW-1:0]        p2_nxt;
    logic [AW-1:0]        rev_nxt;

    always_comb begin
        step_x   = {{(XW-SW){step[SW-1]}}, step};
        step_s   = step_x <<< scale;
        raw      = $signed({2'b00, ptr}) + step_s;
        len_x    = $signed({2'b00, len});
        lo_bound = $signed({2'b00, base});
        hi_bound = lo_bound + len_x;
        if (raw >= hi_bound) begin
            circ = raw - len_x;
        end else if (raw < lo_bound) begin
            circ = raw + len_x;
        end else begin
            circ = raw;
        end
    end

    assign mask   = len - AW'(1);
    assign p2_nxt = (ptr & ~mask) | (raw[AW-1:0] & mask);

    agu_rev_carry #(.AW(AW)) u_rev (
        .cur  (ptr),
        .span (len),
        .nxt  (rev_nxt)
    );

    always_comb begin
        unique case (kind)
            KIND_LIN:  nxt = raw[AW-1:0];
            KIND_CIRC: nxt = circ[AW-1:0];
            KIND_P2:   nxt = p2_nxt;
            KIND_REV:  nxt = rev_nxt;
            default:   nxt = ptr;
        endcase
    end

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
    import agu_pkg::*;
#(
    parameter int  AW     = 16,
    parameter int  NPTR   = 4,
    parameter int  SW     = 8,
    localparam int PSEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PSEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]     cfg_base,
    input  logic [AW-1:0]     cfg_len,
    input  logic              ld_we,
    input  logic [PSEL_W-1:0] ld_sel,
    input  logic [AW-1:0]     ld_val,
    input  logic              adv,
    input  logic [PSEL_W-1:0] adv_sel,
    input  logic [2:0]        adv_mode,
    input  logic [SW-1:0]     adv_step,
    input  logic [1:0]        adv_scale,
    output logic              addr_valid,
    output logic [AW-1:0]     addr_out
);

    agu_kind_e     kind;
    logic          pre;
    logic [AW-1:0] cur_ptr;
    logic [AW-1:0] cur_base;
    logic [AW-1:0] cur_len;
    logic [AW-1:0] nxt_ptr;
    logic [AW-1:0] emit;
    logic          vld_q;
    logic [AW-1:0] addr_q;

    assign kind = agu_kind_e'(adv_mode[2:1]);
    assign pre  = adv_mode[0];

    agu_ptr_file #(.AW(AW), .NPTR(NPTR), .PSEL_W(PSEL_W)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_base (cfg_base),
        .cfg_len  (cfg_len),
        .ld_we    (ld_we),
        .ld_sel   (ld_sel),
        .ld_val   (ld_val),
        .upd_we   (adv),
        .upd_sel  (adv_sel),
        .upd_val  (nxt_ptr),
        .rd_sel   (adv_sel),
        .rd_ptr   (cur_ptr),
        .rd_base  (cur_base),
        .rd_len   (cur_len)
    );

    agu_step_calc #(.AW(AW), .SW(SW)) u_calc (
        .kind  (kind),
        .ptr   (cur_ptr),
        .base  (cur_base),
        .len   (cur_len),
        .step  (adv_step),
        .scale (adv_scale),
        .nxt   (nxt_ptr)
    );

    assign emit = pre ? nxt_ptr : cur_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            vld_q <= adv;
            if (adv) begin
                addr_q <= emit;
            end
        end
    end

    assign addr_valid = vld_q;
    assign addr_out   = addr_q;

endmodule

// File: rtl/dsp_agu_chk.sv
module dsp_agu_chk #(
    parameter int AW     = 16,
    parameter int SW     = 8,
    parameter int PSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_we,
    input logic [PSEL_W-1:0] ld_sel,
    input logic              adv,
    input logic [PSEL_W-1:0] adv_sel,
    input logic [2:0]        adv_mode,
    input logic [SW-1:0]     adv_step,
    input logic [1:0]        adv_scale,
    input logic              addr_valid,
    input logic [AW-1:0]     addr_out
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    function automatic logic [AW-1:0] scaled(logic [SW-1:0] s, logic [1:0] sc);
        logic [AW-1:0] e;
        e = {{(AW-SW){s[SW-1]}}, s};
        return e << sc;
    endfunction

    // R1: quiet outputs while reset is held
    always @(negedge clk) begin
        if (armed && !rst_n) begin
            a_r1_reset_quiet: assert (!addr_valid && addr_out == '0);
        end
    end

    // R2: valid strictly follows the strobe
    a_r2_valid_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> addr_valid);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> (!addr_valid && $stable(addr_out)));

    // R3: back-to-back post-linear advances stride by the earlier step
    a_r3_post_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && adv_mode == 3'b000 && $past(adv) && $past(adv_mode) == 3'b000
         && $past(adv_sel) == adv_sel && !($past(ld_we) && $past(ld_sel) == adv_sel))
        |=> (addr_out == $past(addr_out) + scaled($past(adv_step, 2), $past(adv_scale, 2))));

    // R4: back-to-back pre-linear advances stride by the current step
    a_r4_pre_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && adv_mode == 3'b001 && $past(adv) && $past(adv_mode) == 3'b001
         && $past(adv_sel) == adv_sel && !($past(ld_we) && $past(ld_sel) == adv_sel))
        |=> (addr_out == $past(addr_out) + scaled($past(adv_step), $past(adv_scale))));

endmodule

bind dsp_agu dsp_agu_chk #(.AW(AW), .SW(SW), .PSEL_W(PSEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_we      (ld_we),
    .ld_sel     (ld_sel),
    .adv        (adv),
    .adv_sel    (adv_sel),
    .adv_mode   (adv_mode),
    .adv_step   (adv_step),
    .adv_scale  (adv_scale),
    .addr_valid (addr_valid),
    .addr_out   (addr_out)
);

// File: tb/dsp_agu_bench.sv
module dsp_agu_bench;

    localparam int AW = 16;
    localparam int NPTR = 4;
    localparam int SW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_len = '0;
    logic        ld_we = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_val = '0;
    logic        adv = 1'b0;
    logic [1:0]  adv_sel = '0;
    logic [2:0]  adv_mode = '0;
    logic [7:0]  adv_step = '0;
    logic [1:0]  adv_scale = '0;
    logic        addr_valid;
    logic [15:0] addr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int m_ptr [NPTR];
    int m_base [NPTR];
    int m_len [NPTR];

    always #5ns clk = ~clk;

    dsp_agu #(.AW(AW), .NPTR(NPTR), .SW(SW)) u_dsp_agu (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .ld_we(ld_we), .ld_sel(ld_sel), .ld_val(ld_val),
        .adv(adv), .adv_sel(adv_sel), .adv_mode(adv_mode),
        .adv_step(adv_step), .adv_scale(adv_scale),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int log2i(int v);
        int k = 0;
        while ((1 << k) < v) k++;
        return k;
    endfunction

    function automatic int mirror(int v, int k);
        int r = 0;
        for (int i = 0; i < k; i++)
            if (((v >> i) & 1) != 0) r |= (1 << (k - 1 - i));
        return r;
    endfunction

    function automatic int model_next(int sel, int mode, int step, int scale);
        int p = m_ptr[sel];
        int b = m_base[sel];
        int l = m_len[sel];
        int s = step * (1 << scale);
        int up, off, k, rv;
        case (mode >> 1)
            0: return (p + s) & 'hFFFF;
            1: begin
                off = p - b + s;
                off = ((off % l) + l) % l;
                return b + off;
            end
            2: begin
                up = (p / l) * l;
                return up + ((((p % l) + s) % l) + l) % l;
            end
            default: begin
                up = (p / l) * l;
                k = log2i(l);
                rv = (mirror(p % l, k) + 1) % l;
                return up + mirror(rv, k);
            end
        endcase
    endfunction

    task automatic do_cfg(int sel, int b, int l);
        cfg_we = 1; cfg_sel = sel[1:0]; cfg_base = b[15:0]; cfg_len = l[15:0];
        @(negedge clk);
        cfg_we = 0;
        m_base[sel] = b; m_len[sel] = l;
    endtask

    task automatic do_ld(int sel, int v);
        ld_we = 1; ld_sel = sel[1:0]; ld_val = v[15:0];
        @(negedge clk);
        ld_we = 0;
        m_ptr[sel] = v;
    endtask

    task automatic adv_chk(int sel, int mode, int step, int scale, string req);
        int nx = model_next(sel, mode, step, scale);
        int em = ((mode & 1) != 0) ? nx : m_ptr[sel];
        adv = 1; adv_sel = sel[1:0]; adv_mode = mode[2:0];
        adv_step = step[7:0]; adv_scale = scale[1:0];
        @(negedge clk);
        adv = 0;
        check({req, " valid"}, int'(addr_valid), 1);
        check(req, int'(addr_out), em);
        m_ptr[sel] = nx;
    endtask

    initial begin
        int seq [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
        int held;
        for (int i = 0; i < NPTR; i++) begin
            m_ptr[i] = 0; m_base[i] = 0; m_len[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(addr_valid), 0);
        check("R1 addr in reset", int'(addr_out), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 valid after reset", int'(addr_valid), 0);
        check("R1 addr after reset", int'(addr_out), 0);
        for (int i = 0; i < NPTR; i++) adv_chk(i, 0, 0, 0, "R1 pointer cleared");

        // R3 R4 R5: linear sweep over steps, scales, pre/post
        do_ld(0, 3);
        for (int sc = 0; sc < 4; sc++)
            foreach (seq[j]) begin
                int steps [7] = '{-128, -5, -1, 0, 1, 7, 127};
                if (j < 7) begin
                    adv_chk(0, 0, steps[j], sc, "R3 post linear");
                    adv_chk(0, 1, steps[j], sc, "R4 pre linear");
                end
            end
        do_ld(0, 'hFFFE);
        adv_chk(0, 0, 2, 1, "R5 wrap up");
        adv_chk(0, 1, -3, 2, "R5 wrap down");

        // R2: idle cycle keeps address, drops valid
        held = int'(addr_out);
        @(negedge clk);
        check("R2 idle valid", int'(addr_valid), 0);
        check("R2 idle hold", int'(addr_out), held);

        // R6: circular sweep, length 7 at start 100
        do_cfg(1, 100, 7);
        for (int st = 0; st < 7; st++)
            for (int sp = -6; sp <= 6; sp++)
                for (int pr = 0; pr < 2; pr++) begin
                    do_ld(1, 100 + st);
                    adv_chk(1, 2 + pr, sp, 0, "R6 circular");
                end
        do_ld(1, 105);
        adv_chk(1, 2, 3, 1, "R6 scaled wrap");
        adv_chk(1, 3, -3, 1, "R6 scaled wrap down");
        adv_chk(1, 0, 0, 0, "R6 end pointer");

        // R7: aligned circular, size 16, start ignored
        do_cfg(2, 999, 16);
        foreach (seq[j]) begin
            if (j < 3) begin
                for (int sp = -15; sp <= 15; sp += 2)
                    for (int pr = 0; pr < 2; pr++) begin
                        do_ld(2, 'h1230 + 7 * j + (j == 2 ? 1 : 0));
                        adv_chk(2, 4 + pr, sp, 0, "R7 aligned circular");
                    end
            end
        end

        // R8: bit-reversed 8 points, step and scale ignored
        do_cfg(3, 0, 8);
        do_ld(3, 0);
        for (int r = 0; r < 16; r++) begin
            adv_chk(3, 6, 5, 3, "R8 reversed");
            check("R8 literal order", int'(addr_out), seq[r % 8]);
        end
        // R9: pre emission on bit-reversed, 16 points with upper bits
        do_cfg(3, 0, 16);
        do_ld(3, 'h50);
        for (int r = 0; r < 20; r++) adv_chk(3, 7, -1, 0, "R9 pre reversed");

        // R10: load collides with advance on the same pointer
        do_ld(1, 102);
        ld_we = 1; ld_sel = 2'd1; ld_val = 16'd104;
        adv_chk(1, 2, 1, 0, "R10 old pointer emitted");
        ld_we = 0;
        m_ptr[1] = 104;
        adv_chk(1, 0, 1, 0, "R10 load wins");

        // R11: other pointers untouched
        do_ld(2, 'h4444);
        for (int r = 0; r < 5; r++) adv_chk(0, 0, 9, 0, "R11 busy pointer");
        adv_chk(2, 0, 0, 0, "R11 idle pointer");
        adv_chk(1, 0, 0, 0, "R11 idle pointer");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1ms;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule